// File: doc/BRIEF.md
# Main-Link Training and Idle Pattern Sequencer

This block drives the per-lane symbol stream of a display transmitter's main link during bring-up, before any pixel data flows. Configuration logic asks for a stage on a two-bit request input. The block moves through the stages in a fixed order: clock-recovery training, then symbol-alignment training, then the idle pattern, and finally the video stage. Requests that would break that order are ignored. On every clock it presents one byte plus a control flag per lane, ready for a downstream 8b/10b encoder. It also raises a scrambler-enable flag, but only once video has begun.

In the idle and video stages the stream is framed into periods of `BS_PERIOD` symbols. Each period starts with a Blank Start control symbol. A stage change asked for in the middle of a period waits for the end of that period. This keeps the Blank Start cadence intact, and the first symbol of every new idle run is a Blank Start. An `idle_ok` status output goes high once five complete idle periods have gone out. The move to video is refused until that count has been reached.

Top module: `link_pattern_seq`

## Requirements
- R1: In the clock-recovery stage (stage code 0), every active lane carries the data byte 0x4A (D10.2, control flag 0) on every cycle.
- R2: In the alignment stage (code 1), every active lane repeats a 10-symbol cycle. Positions 0 and 2 carry control 0xBC (comma), positions 1 and 3 carry data 0xCB, and positions 4 to 9 carry data 0x4A. The cycle starts at position 0 on entry.
- R3: In the idle stage (code 2), position 1 of each period carries the VB-ID data byte 0x09 (bit 0 vertical blanking, bit 3 no video, all other bits clear). Positions 2 to `BS_PERIOD`-1 carry data 0x00, which covers the zero Mvid and Maud fields.
- R4: In the idle and video stages (codes 2 and 3), position 0 of each `BS_PERIOD`-symbol period is control 0xBC (Blank Start). The position counter restarts at 0 on every stage change. In video, all other positions carry data 0x00.
- R5: The stage changes only along the allowed edges: 0→1, 1→2, 2→3, 3→2, and any stage →0. Every other request, including a request for the current stage, is ignored. The current stage code appears on `stage_now`.
- R6: `idle_ok` is high once `MIN_IDLE` (5) complete idle periods have been sent since the idle stage was last entered. A move from idle to video takes effect only at the boundary that completes the fifth period, or at a later boundary. Any accepted change to a stage other than video clears the count.
- R7: `scram_en` is high exactly while the stage is video, and is low in both training stages and in idle.
- R8: `lane_mode` selects the active lanes: 0 = lane 0, 1 = lanes 0–1, 2 or 3 = lanes 0–3. Every active lane carries the same symbol in the same cycle. Inactive lanes output data 0x00 with control flag 0.
- R9: A change out of the idle or video stage is applied only at the clock edge that ends a period, when position `BS_PERIOD`-1 is being sent.
- R10: After reset the stage is clock-recovery, the position is 0, `idle_ok` is low and `scram_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link symbol clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stage_req | input | 2 | Requested stage (0 clock-recovery, 1 alignment, 2 idle, 3 video) |
| lane_mode | input | 2 | Active lane count select (0: one, 1: two, 2/3: four) |
| lane_data | output | MAX_LANES*8 | Symbol byte per lane, lane n in bits [8n+7:8n] |
| lane_k | output | MAX_LANES | Control-symbol flag per lane |
| scram_en | output | 1 | Scrambler enable, high only in video |
| idle_ok | output | 1 | Enough idle periods sent for video |
| stage_now | output | 2 | Current stage code |

## Verification
The bench runs a short period (16 symbols) and holds the video request throughout idle. A design that counted idle periods off by one would reach video one period early or one period late, or would raise `idle_ok` in the wrong cycle. It asks to leave idle and video in the middle of a period. A design that switched at once would cut a period short and lose the leading Blank Start. It also sends requests that skip stages, and it walks `lane_mode` through all four values. An order check missing from the design would jump straight to idle or video, and wrong lane masking would leave a stale symbol on a lane that should be off. Every cycle is compared against an arithmetic stage and position model. Any misplaced symbol within the 10-symbol alignment cycle or the idle framing therefore shows up at its exact position.

// File: rtl/link_seq_pkg.sv
// Shared types and symbol constants for the main-link pattern sequencer.
// Assumes a downstream 8b/10b encoder that takes a byte plus control flag.
package link_seq_pkg;

    typedef enum logic [1:0] {
        STG_CLKREC = 2'd0,
        STG_ALIGN  = 2'd1,
        STG_IDLE   = 2'd2,
        STG_VIDEO  = 2'd3
    } stage_e;

    typedef struct packed {
        logic       k;
        logic [7:0] d;
    } sym_t;

    localparam logic [7:0] SYM_COMMA  = 8'hBC;  // K28.5, also used as Blank Start
    localparam logic [7:0] SYM_D10_2  = 8'h4A;  // alternating-bit training symbol
    localparam logic [7:0] SYM_D11_6  = 8'hCB;  // follows each comma in alignment
    localparam logic [7:0] VBID_IDLE  = 8'h09;  // blanking + no-video flags
    localparam int         ALIGN_LEN  = 10;

endpackage

// File: rtl/lps_stage_ctrl.sv
// Stage sequencer: holds the current stage, the symbol position and the
// count of completed idle periods. Enforces the allowed stage order and
// defers exits from idle/video to the end of a framing period.
// Assumes BS_PERIOD >= 16 and MIN_IDLE >= 1.
module lps_stage_ctrl
    import link_seq_pkg::*;
#(
    parameter int BS_PERIOD = 8192,
    parameter int MIN_IDLE  = 5,
    localparam int PW = $clog2(BS_PERIOD),
    localparam int CW = $clog2(MIN_IDLE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    req_i,
    output stage_e        stage_o,
    output logic [PW-1:0] pos_o,
    output logic          idle_ok_o
);

    stage_e        stage_q;
    stage_e        req_s;
    logic [PW-1:0] pos_q;
    logic [PW-1:0] wrap_pos;
    logic [CW-1:0] cnt_q;
    logic          boundary;
    logic          legal;
    logic          take;

    assign req_s    = stage_e'(req_i);
    assign wrap_pos = (stage_q == STG_ALIGN) ? PW'(ALIGN_LEN - 1) : PW'(BS_PERIOD - 1);
    assign boundary = (pos_q == PW'(BS_PERIOD - 1));

    // Decide whether the requested stage is an allowed next step.
    always_comb begin
        case (stage_q)
            STG_CLKREC: legal = (req_s == STG_ALIGN);
            STG_ALIGN:  legal = (req_s == STG_IDLE) || (req_s == STG_CLKREC);
            STG_IDLE:   legal = (req_s == STG_CLKREC) ||
                                ((req_s == STG_VIDEO) && (cnt_q >= CW'(MIN_IDLE - 1)));
            STG_VIDEO:  legal = (req_s == STG_CLKREC) || (req_s == STG_IDLE);
            default:    legal = 1'b0;
        endcase
    end

    // Training stages switch at once; framed stages wait for a period end.
    assign take = legal && ((stage_q == STG_CLKREC) || (stage_q == STG_ALIGN) || boundary);

    // Stage register.
    always_ff @(posedge clk) begin
        if (!rst_n)    stage_q <= STG_CLKREC;
        else if (take) stage_q <= req_s;
    end

    // Symbol position: restarts on a stage change, wraps per stage length.
    always_ff @(posedge clk) begin
        if (!rst_n)                pos_q <= '0;
        else if (take)             pos_q <= '0;
        else if (pos_q == wrap_pos) pos_q <= '0;
        else                       pos_q <= pos_q + 1'b1;
    end

    // Completed idle periods, saturating at MIN_IDLE.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (take && (req_s != STG_VIDEO))
            cnt_q <= '0;
        else if ((stage_q == STG_IDLE) && boundary && (cnt_q < CW'(MIN_IDLE)))
            cnt_q <= cnt_q + 1'b1;
    end

    assign stage_o   = stage_q;
    assign pos_o     = pos_q;
    assign idle_ok_o = (cnt_q >= CW'(MIN_IDLE));

    AST_ORDER_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == STG_ALIGN && $past(stage_q) != STG_ALIGN) |-> $past(stage_q) == STG_CLKREC); // R5
    AST_ORDER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == STG_IDLE && $past(stage_q) != STG_IDLE) |->
        ($past(stage_q) == STG_ALIGN || $past(stage_q) == STG_VIDEO)); // R5
    AST_VIDEO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == STG_VIDEO && $past(stage_q) != STG_VIDEO) |->
        ($past(stage_q) == STG_IDLE && idle_ok_o)); // R6
    AST_IDLE_EXIT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stage_q) == STG_IDLE && stage_q != STG_IDLE) |->
        $past(pos_q) == PW'(BS_PERIOD - 1)); // R9
    AST_POS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q != $past(stage_q)) |-> pos_q == '0); // R4
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MIN_IDLE)); // R6

endmodule

// File: rtl/lps_symbol_gen.sv
// Symbol generator: maps stage and position to one byte plus control flag.
// Purely combinational; assumes the position is already wrapped per stage.
module lps_symbol_gen
    import link_seq_pkg::*;
#(
    parameter int PW = 13
) (
    input  stage_e        stage_i,
    input  logic [PW-1:0] pos_i,
    output sym_t          sym_o
);

    // Select the symbol for the current stage and position.
    always_comb begin
        sym_o = '{k: 1'b0, d: 8'h00};
        case (stage_i)
            STG_CLKREC: sym_o = '{k: 1'b0, d: SYM_D10_2};
            STG_ALIGN: begin
                if (pos_i == PW'(0) || pos_i == PW'(2))
                    sym_o = '{k: 1'b1, d: SYM_COMMA};
                else if (pos_i == PW'(1) || pos_i == PW'(3))
                    sym_o = '{k: 1'b0, d: SYM_D11_6};
                else
                    sym_o = '{k: 1'b0, d: SYM_D10_2};
            end
            STG_IDLE: begin
                if (pos_i == PW'(0))      sym_o = '{k: 1'b1, d: SYM_COMMA};
                else if (pos_i == PW'(1)) sym_o = '{k: 1'b0, d: VBID_IDLE};
            end
            STG_VIDEO: begin
                if (pos_i == PW'(0))      sym_o = '{k: 1'b1, d: SYM_COMMA};
            end
            default: sym_o = '{k: 1'b0, d: 8'h00};
        endcase
    end

endmodule

// File: rtl/lps_lane_fan.sv
// Lane fan-out: copies one symbol onto every active lane and zeroes the
// rest. Assumes MAX_LANES is 1, 2 or 4.
module lps_lane_fan
    import link_seq_pkg::*;
#(
    parameter int MAX_LANES = 4
) (
    input  sym_t                     sym_i,
    input  logic [1:0]               lane_mode_i,
    output logic [MAX_LANES*8-1:0]   data_o,
    output logic [MAX_LANES-1:0]     k_o
);

    int n_active;

    // Decode the lane mode into a count of active lanes.
    always_comb begin
        case (lane_mode_i)
            2'd0:    n_active = 1;
            2'd1:    n_active = 2;
            default: n_active = 4;
        endcase
    end

    for (genvar l = 0; l < MAX_LANES; l++) begin : g_lane
        // Drive one lane, or hold it quiet when not in use.
        always_comb begin
            if (l < n_active) begin
                data_o[l*8 +: 8] = sym_i.d;
                k_o[l]           = sym_i.k;
            end else begin
                data_o[l*8 +: 8] = 8'h00;
                k_o[l]           = 1'b0;
            end
        end
    end

endmodule

// File: rtl/link_pattern_seq.sv
// Top of the main-link training and idle pattern sequencer. Ties the stage
// sequencer, symbol generator and lane fan-out together and derives the
// scrambler enable. Assumes the encoder and scrambler sit downstream.
module link_pattern_seq
    import link_seq_pkg::*;
#(
    parameter int MAX_LANES = 4,
    parameter int BS_PERIOD = 8192,
    parameter int MIN_IDLE  = 5,
    localparam int PW = $clog2(BS_PERIOD)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             stage_req,
    input  logic [1:0]             lane_mode,
    output logic [MAX_LANES*8-1:0] lane_data,
    output logic [MAX_LANES-1:0]   lane_k,
    output logic                   scram_en,
    output logic                   idle_ok,
    output logic [1:0]             stage_now
);

    stage_e        stage;
    logic [PW-1:0] pos;
    sym_t          sym;

    lps_stage_ctrl #(.BS_PERIOD(BS_PERIOD), .MIN_IDLE(MIN_IDLE)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (stage_req),
        .stage_o  (stage),
        .pos_o    (pos),
        .idle_ok_o(idle_ok)
    );

    lps_symbol_gen #(.PW(PW)) u_gen (
        .stage_i(stage),
        .pos_i  (pos),
        .sym_o  (sym)
    );

    lps_lane_fan #(.MAX_LANES(MAX_LANES)) u_fan (
        .sym_i      (sym),
        .lane_mode_i(lane_mode),
        .data_o     (lane_data),
        .k_o        (lane_k)
    );

    // Scrambling runs only once video has started.
    assign scram_en  = (stage == STG_VIDEO);
    assign stage_now = stage;

    AST_SCRAM_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        scram_en |-> idle_ok); // R7
    AST_IDLE_STARTS_BS: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == STG_IDLE && $past(stage) != STG_IDLE) |-> lane_k[0]); // R4

endmodule

// File: tb/link_pattern_seq_bench.sv
`timescale 1ns/1ps
module link_pattern_seq_bench;

    localparam int LANES = 4;
    localparam int P     = 16;
    localparam int MINI  = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       stage_req = 2'd0;
    logic [1:0]       lane_mode = 2'd2;
    logic [LANES*8-1:0] lane_data;
    logic [LANES-1:0] lane_k;
    logic             scram_en;
    logic             idle_ok;
    logic [1:0]       stage_now;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int m_stage = 0;
    int m_pos   = 0;
    int m_cnt   = 0;

    always #2.5 clk = ~clk;

    link_pattern_seq #(.MAX_LANES(LANES), .BS_PERIOD(P), .MIN_IDLE(MINI)) u_link_pattern_seq (
        .clk(clk), .rst_n(rst_n), .stage_req(stage_req), .lane_mode(lane_mode),
        .lane_data(lane_data), .lane_k(lane_k), .scram_en(scram_en),
        .idle_ok(idle_ok), .stage_now(stage_now)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (stage %0d pos %0d)",
                     tag, what, act, exp, m_stage, m_pos);
        end
    endtask

    function automatic int exp_sym(int st, int p);
        case (st)
            0: return 9'h04A;
            1: begin
                if (p == 0 || p == 2) return 9'h1BC;
                if (p == 1 || p == 3) return 9'h0CB;
                return 9'h04A;
            end
            2: begin
                if (p == 0) return 9'h1BC;
                if (p == 1) return 9'h009;
                return 0;
            end
            default: return (p == 0) ? 9'h1BC : 0;
        endcase
    endfunction

    // Compare every output against the stage/position model.
    task automatic check_all();
        int nl;
        int e;
        string tag;
        nl  = (lane_mode == 2'd0) ? 1 : (lane_mode == 2'd1) ? 2 : 4;
        e   = exp_sym(m_stage, m_pos);
        case (m_stage)
            0: tag = "R1";
            1: tag = "R2";
            2: tag = (m_pos == 0) ? "R4" : "R3";
            default: tag = "R4";
        endcase
        for (int l = 0; l < LANES; l++) begin
            if (l < nl) chk(tag, $sformatf("R8 lane %0d symbol", l),
                            {23'd0, lane_k[l], lane_data[l*8 +: 8]}, e);
            else        chk("R8", $sformatf("lane %0d off", l),
                            {23'd0, lane_k[l], lane_data[l*8 +: 8]}, 0);
        end
        chk("R5 R9", "stage", int'(stage_now), m_stage);
        chk("R7", "scram_en", int'(scram_en), int'(m_stage == 3));
        chk("R6", "idle_ok", int'(idle_ok), int'(m_cnt >= MINI));
    endtask

    // Advance the model across one clock edge for request r.
    task automatic model_next(int r);
        bit b;
        bit lg;
        bit tk;
        int wrapv;
        b = (m_pos == P - 1);
        case (m_stage)
            0: lg = (r == 1);
            1: lg = (r == 2) || (r == 0);
            2: lg = (r == 0) || (r == 3 && m_cnt >= MINI - 1);
            default: lg = (r == 0) || (r == 2);
        endcase
        tk = lg && (m_stage < 2 || b);
        if (tk && r != 3) m_cnt = 0;
        else if (m_stage == 2 && b && m_cnt < MINI) m_cnt++;
        wrapv = (m_stage == 1) ? 9 : P - 1;
        if (tk) m_pos = 0;
        else    m_pos = (m_pos == wrapv) ? 0 : m_pos + 1;
        if (tk) m_stage = r;
    endtask

    task automatic step(int r, int mode, int n);
        for (int i = 0; i < n; i++) begin
            stage_req = r[1:0];
            lane_mode = mode[1:0];
            model_next(r);
            @(negedge clk);
            check_all();
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        chk("R10", "stage after reset", int'(stage_now), 0);
        chk("R10", "idle_ok after reset", int'(idle_ok), 0);
        chk("R10", "scram_en after reset", int'(scram_en), 0);
        chk("R10", "lane0 after reset", {23'd0, lane_k[0], lane_data[7:0]}, 9'h04A);
        // R1, R8: clock recovery across every lane mode
        for (int m = 0; m < 4; m++) step(0, m, 4);
        // R5: skipping requests ignored
        step(3, 2, 5);
        step(2, 2, 5);
        // R2: alignment cycles, skip to video ignored
        step(1, 2, 23);
        step(3, 1, 3);
        // R3, R4, R6: idle with video held requested from the start
        step(2, 2, 1);
        step(3, 2, 5 * P + 3);
        step(3, 1, 20);
        // R9: return to idle requested mid-period
        step(2, 0, 2 * P + 5);
        step(2, 3, P);
        // R9: retrain requested mid-period, then full sequence again
        step(0, 2, P + 3);
        step(1, 2, 12);
        step(2, 2, 3 * P);
        step(0, 2, P);
        step(1, 2, 5);
        step(2, 2, 4 * P + 2);
        step(3, 2, 2 * P + 4);
        step(3, 3, 20);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(100000 * 5.0);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule